// File: doc/BRIEF.md
# AXI ID Filtered Traffic Counter

This block watches the read-address and write-address channels of one or more AXI ports and, for each of a small set of event counters, works out how much matching traffic was accepted in each clock cycle. A transaction qualifies when its address handshake completes and its ID agrees with a programmed ID on the bit positions a programmed mask selects. For every counter the block presents two per-cycle increments: the number of qualifying bursts and the number of bytes those bursts move. The counter storage and any overflow or interrupt handling sit downstream and simply add these increments.

Software configures the block through a simple write port. Each counter has an event code that picks filtered reads or filtered writes, and a routing word that either limits the counter to one port or lets it watch every port. The ID filter is held in one word: the ID in the low half and the compare mask, stored inverted, in the high half. A build parameter chooses whether all counters share one filter word or each counter has its own.

Top module: `axi_id_traffic_tap`

## Requirements
- R1: While reset is high and on the first cycle after it, every burst and byte increment is zero; all configuration words reset to zero.
- R2: An ID matches when ((id XOR W[15:0]) AND NOT W[31:16]) is zero, where W is the filter word; the high half holds the compare mask inverted, so a stored 0 bit means "compare this bit".
- R3: A counter whose event code is 0x41 counts read-address traffic only, 0x42 counts write-address traffic only, and any other code gives zero increments.
- R4: A transaction is counted once, only in a cycle where its valid and ready are both high; the increments for a handshake appear on the output in the cycle after the edge that sampled it.
- R5: The byte increment adds (len+1) shifted left by size for each counted transaction.
- R6: In a counter's routing word, bits 2:0 name the read port and bit 3 is a stored-inverted read select (0: count only the named port, 1: count every port); bits 10:8 and bit 11 do the same for writes.
- R7: Handshakes on several ports in the same cycle are summed, and read and write channels are evaluated independently, so a read counter and a write counter both see a cycle in which both channels handshake.
- R8: With the default shared-filter build, every counter uses the filter word at address 0x00, and writes to the per-counter filter address (0x10*n+0x4) have no effect on counting.
- R9: Configuration writes (addresses 0x00, and 0x10*n+0x0 event, +0x4 filter, +0x8 routing for counter n) take effect from the cycle after the write; a handshake in the write cycle is judged by the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| ar_valid | input | NUM_PORTS | Read-address valid per port |
| ar_ready | input | NUM_PORTS | Read-address ready per port |
| ar_id | input | NUM_PORTS*16 | Read-address ID per port |
| ar_len | input | NUM_PORTS*LEN_W | Read burst length minus one per port |
| ar_size | input | NUM_PORTS*SIZE_W | Read beat size code per port |
| aw_valid | input | NUM_PORTS | Write-address valid per port |
| aw_ready | input | NUM_PORTS | Write-address ready per port |
| aw_id | input | NUM_PORTS*16 | Write-address ID per port |
| aw_len | input | NUM_PORTS*LEN_W | Write burst length minus one per port |
| aw_size | input | NUM_PORTS*SIZE_W | Write beat size code per port |
| burst_inc | output | NUM_CNT*BURST_W | Per-counter burst increment |
| byte_inc | output | NUM_CNT*BYTE_W | Per-counter byte increment |

## Verification
Every increment is due exactly one clock after the edge that sampled its handshake, and a configuration write changes behaviour one clock after its own edge. The bench drives inputs on the falling edge, predicts each counter's increments from the inputs and configuration in force at the next rising edge, applies any pending write to its model only after that prediction, and compares on the following falling edge. This ordering makes the same-cycle write case a direct test of the old-value rule.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam int FID_W        = 16;
  localparam int FWORD_W      = 32;
  localparam int EV_W         = 8;
  localparam int PORT_FIELD_W = 3;
  localparam int ROUTE_W      = 12;

  localparam logic [EV_W-1:0] EV_FILT_RD = 8'h41;
  localparam logic [EV_W-1:0] EV_FILT_WR = 8'h42;

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_FILTER = 2'd1,
    REG_ROUTE  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // High half of the filter word holds the compare mask inverted.
  function automatic logic id_hit(input logic [FID_W-1:0] id,
                                  input logic [FWORD_W-1:0] fw);
    logic [FID_W-1:0] cmp;
    cmp = ~fw[FWORD_W-1:FID_W];
    return ((id ^ fw[FID_W-1:0]) & cmp) == '0;
  endfunction
endpackage

// File: rtl/axf_cfg_regs.sv
module axf_cfg_regs
  import axf_pkg::*;
#(
  parameter int NUM_CNT        = 3,
  parameter bit PER_CNT_FILTER = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [7:0]                        cfg_addr,
  input  logic [31:0]                       cfg_wdata,
  output logic [NUM_CNT-1:0][EV_W-1:0]      ev_code,
  output logic [NUM_CNT-1:0][ROUTE_W-1:0]   route,
  output logic [NUM_CNT-1:0][FWORD_W-1:0]   eff_filter
);
  logic [3:0]         slot;
  reg_sel_e           sel;
  logic               wr_ok;
  logic [FWORD_W-1:0] shared_q;

  assign slot  = cfg_addr[7:4];
  assign sel   = reg_sel_e'(cfg_addr[3:2]);
  assign wr_ok = cfg_we && (cfg_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      shared_q <= '0;
      ev_code  <= '0;
      route    <= '0;
    end else if (wr_ok) begin
      if (slot == 4'd0 && sel == REG_EVENT) shared_q <= cfg_wdata;
      for (int c = 0; c < NUM_CNT; c++) begin
        if (slot == 4'(c + 1)) begin
          if (sel == REG_EVENT) ev_code[c] <= cfg_wdata[EV_W-1:0];
          if (sel == REG_ROUTE) route[c]   <= cfg_wdata[ROUTE_W-1:0];
        end
      end
    end
  end

  generate
    if (PER_CNT_FILTER) begin : g_own_filter
      logic [NUM_CNT-1:0][FWORD_W-1:0] own_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          own_q <= '0;
        end else if (wr_ok) begin
          for (int c = 0; c < NUM_CNT; c++)
            if (slot == 4'(c + 1) && sel == REG_FILTER) own_q[c] <= cfg_wdata;
        end
      end
      assign eff_filter = own_q;
    end else begin : g_shared_filter
      for (genvar c = 0; c < NUM_CNT; c++) begin : g_fan
        assign eff_filter[c] = shared_q;
      end
    end
  endgenerate
endmodule

// File: rtl/axf_chan_tap.sv
module axf_chan_tap
  import axf_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int LEN_W     = 8,
  parameter int SIZE_W    = 3,
  parameter int BURST_W   = 2,
  parameter int BYTE_W    = 17
) (
  input  logic [NUM_PORTS-1:0]        valid,
  input  logic [NUM_PORTS-1:0]        ready,
  input  logic [NUM_PORTS*FID_W-1:0]  id,
  input  logic [NUM_PORTS*LEN_W-1:0]  len,
  input  logic [NUM_PORTS*SIZE_W-1:0] size,
  input  logic [FWORD_W-1:0]          fword,
  input  logic                        lim_en,
  input  logic [PORT_FIELD_W-1:0]     port_sel,
  output logic [BURST_W-1:0]          burst,
  output logic [BYTE_W-1:0]           bytes
);
  always_comb begin
    burst = '0;
    bytes = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (valid[p] && ready[p] &&
          (!lim_en || port_sel == PORT_FIELD_W'(p)) &&
          id_hit(id[p*FID_W +: FID_W], fword)) begin
        burst = burst + BURST_W'(1);
        bytes = bytes + ((BYTE_W'(len[p*LEN_W +: LEN_W]) + BYTE_W'(1))
                         << size[p*SIZE_W +: SIZE_W]);
      end
    end
  end
endmodule

// File: rtl/axi_id_traffic_tap.sv
module axi_id_traffic_tap
  import axf_pkg::*;
#(
  parameter int NUM_PORTS      = 2,
  parameter int NUM_CNT        = 3,
  parameter int LEN_W          = 8,
  parameter int SIZE_W         = 3,
  parameter bit PER_CNT_FILTER = 1'b0,
  localparam int BURST_W       = $clog2(NUM_PORTS + 1),
  localparam int BYTE_W        = LEN_W + (1 << SIZE_W) + $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [7:0]                  cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  input  logic [NUM_PORTS-1:0]        ar_valid,
  input  logic [NUM_PORTS-1:0]        ar_ready,
  input  logic [NUM_PORTS*16-1:0]     ar_id,
  input  logic [NUM_PORTS*LEN_W-1:0]  ar_len,
  input  logic [NUM_PORTS*SIZE_W-1:0] ar_size,
  input  logic [NUM_PORTS-1:0]        aw_valid,
  input  logic [NUM_PORTS-1:0]        aw_ready,
  input  logic [NUM_PORTS*16-1:0]     aw_id,
  input  logic [NUM_PORTS*LEN_W-1:0]  aw_len,
  input  logic [NUM_PORTS*SIZE_W-1:0] aw_size,
  output logic [NUM_CNT*BURST_W-1:0]  burst_inc,
  output logic [NUM_CNT*BYTE_W-1:0]   byte_inc
);
  logic [NUM_CNT-1:0][EV_W-1:0]    ev_code;
  logic [NUM_CNT-1:0][ROUTE_W-1:0] route;
  logic [NUM_CNT-1:0][FWORD_W-1:0] eff_filter;

  axf_cfg_regs #(
    .NUM_CNT        (NUM_CNT),
    .PER_CNT_FILTER (PER_CNT_FILTER)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .ev_code    (ev_code),
    .route      (route),
    .eff_filter (eff_filter)
  );

  generate
    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
      logic [BURST_W-1:0] rd_burst, wr_burst, burst_q;
      logic [BYTE_W-1:0]  rd_bytes, wr_bytes, bytes_q;

      // Routing word: [2:0] read port, [3] read select (inverted),
      // [10:8] write port, [11] write select (inverted).
      axf_chan_tap #(
        .NUM_PORTS (NUM_PORTS), .LEN_W (LEN_W), .SIZE_W (SIZE_W),
        .BURST_W   (BURST_W),   .BYTE_W (BYTE_W)
      ) u_rd (
        .valid    (ar_valid),
        .ready    (ar_ready),
        .id       (ar_id),
        .len      (ar_len),
        .size     (ar_size),
        .fword    (eff_filter[c]),
        .lim_en   (~route[c][3]),
        .port_sel (route[c][2:0]),
        .burst    (rd_burst),
        .bytes    (rd_bytes)
      );

      axf_chan_tap #(
        .NUM_PORTS (NUM_PORTS), .LEN_W (LEN_W), .SIZE_W (SIZE_W),
        .BURST_W   (BURST_W),   .BYTE_W (BYTE_W)
      ) u_wr (
        .valid    (aw_valid),
        .ready    (aw_ready),
        .id       (aw_id),
        .len      (aw_len),
        .size     (aw_size),
        .fword    (eff_filter[c]),
        .lim_en   (~route[c][11]),
        .port_sel (route[c][10:8]),
        .burst    (wr_burst),
        .bytes    (wr_bytes)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          burst_q <= '0;
          bytes_q <= '0;
        end else begin
          case (ev_code[c])
            EV_FILT_RD: begin burst_q <= rd_burst; bytes_q <= rd_bytes; end
            EV_FILT_WR: begin burst_q <= wr_burst; bytes_q <= wr_bytes; end
            default:    begin burst_q <= '0;       bytes_q <= '0;       end
          endcase
        end
      end

      assign burst_inc[c*BURST_W +: BURST_W] = burst_q;
      assign byte_inc[c*BYTE_W +: BYTE_W]    = bytes_q;
    end
  endgenerate
endmodule

// File: rtl/axf_checker.sv
module axf_checker #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_CNT   = 3,
  parameter int BURST_W   = 2,
  parameter int BYTE_W    = 17
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_PORTS-1:0]       ar_valid,
  input logic [NUM_PORTS-1:0]       ar_ready,
  input logic [NUM_PORTS-1:0]       aw_valid,
  input logic [NUM_PORTS-1:0]       aw_ready,
  input logic [NUM_CNT*BURST_W-1:0] burst_inc,
  input logic [NUM_CNT*BYTE_W-1:0]  byte_inc
);
  generate
    for (genvar c = 0; c < NUM_CNT; c++) begin : g_chk
      AST_RST_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (burst_inc[c*BURST_W +: BURST_W] == '0 &&
                        byte_inc[c*BYTE_W +: BYTE_W] == '0)); // R1
      AST_NO_HS_NO_INC: assert property (@(posedge clk) disable iff (rst)
        !$past((|(ar_valid & ar_ready)) || (|(aw_valid & aw_ready)))
          |-> burst_inc[c*BURST_W +: BURST_W] == '0); // R4
      AST_BYTES_COVER_BURSTS: assert property (@(posedge clk) disable iff (rst)
        byte_inc[c*BYTE_W +: BYTE_W] >= BYTE_W'(burst_inc[c*BURST_W +: BURST_W])); // R5
      AST_ZERO_BURST_ZERO_BYTES: assert property (@(posedge clk) disable iff (rst)
        burst_inc[c*BURST_W +: BURST_W] == '0 |-> byte_inc[c*BYTE_W +: BYTE_W] == '0); // R5
      AST_BURST_BOUND: assert property (@(posedge clk) disable iff (rst)
        burst_inc[c*BURST_W +: BURST_W] <= BURST_W'(NUM_PORTS)); // R7
    end
  endgenerate
endmodule

bind axi_id_traffic_tap axf_checker #(
  .NUM_PORTS (NUM_PORTS),
  .NUM_CNT   (NUM_CNT),
  .BURST_W   (BURST_W),
  .BYTE_W    (BYTE_W)
) u_axf_checker (
  .clk       (clk),
  .rst       (rst),
  .ar_valid  (ar_valid),
  .ar_ready  (ar_ready),
  .aw_valid  (aw_valid),
  .aw_ready  (aw_ready),
  .burst_inc (burst_inc),
  .byte_inc  (byte_inc)
);

// File: tb/tb_axi_id_traffic_tap.sv
module tb_axi_id_traffic_tap;
  localparam int NP = 2;
  localparam int NC = 3;
  localparam int LW = 8;
  localparam int SW = 3;
  localparam int BW = 2;
  localparam int YW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NP-1:0] ar_valid = '0, ar_ready = '0, aw_valid = '0, aw_ready = '0;
  logic [NP*16-1:0] ar_id = '0, aw_id = '0;
  logic [NP*LW-1:0] ar_len = '0, aw_len = '0;
  logic [NP*SW-1:0] ar_size = '0, aw_size = '0;
  logic [NC*BW-1:0] burst_inc;
  logic [NC*YW-1:0] byte_inc;

  axi_id_traffic_tap #(.NUM_PORTS(NP), .NUM_CNT(NC), .LEN_W(LW), .SIZE_W(SW))
  dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len), .aw_size(aw_size),
    .burst_inc(burst_inc), .byte_inc(byte_inc)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  bit done = 0;

  // Reference state
  int m_ev[NC];
  int m_route[NC];
  logic [31:0] m_filter;
  int exp_b[NC];
  int exp_y[NC];

  task automatic predict();
    for (int c = 0; c < NC; c++) begin
      int rdsel, half, nb, ny;
      exp_b[c] = 0; exp_y[c] = 0;
      if (rst) continue;
      if (m_ev[c] != 'h41 && m_ev[c] != 'h42) continue;
      rdsel = (m_ev[c] == 'h41);
      half = rdsel ? (m_route[c] & 'hF) : ((m_route[c] >> 8) & 'hF);
      nb = 0; ny = 0;
      for (int p = 0; p < NP; p++) begin
        bit hs;
        int id, ln, sz;
        hs = rdsel ? (ar_valid[p] & ar_ready[p]) : (aw_valid[p] & aw_ready[p]);
        id = rdsel ? int'(ar_id[p*16 +: 16]) : int'(aw_id[p*16 +: 16]);
        ln = rdsel ? int'(ar_len[p*LW +: LW]) : int'(aw_len[p*LW +: LW]);
        sz = rdsel ? int'(ar_size[p*SW +: SW]) : int'(aw_size[p*SW +: SW]);
        if (!hs) continue;
        if (((half >> 3) & 1) == 0 && (half & 7) != p) continue;
        if (((id ^ int'(m_filter[15:0])) & ~int'(m_filter[31:16]) & 'hFFFF) != 0) continue;
        nb++;
        ny += (ln + 1) << sz;
      end
      exp_b[c] = nb; exp_y[c] = ny;
    end
  endtask

  task automatic model_cfg();
    if (rst) begin
      m_filter = '0;
      for (int c = 0; c < NC; c++) begin m_ev[c] = 0; m_route[c] = 0; end
    end else if (cfg_we && cfg_addr[1:0] == 2'b00) begin
      int slot, sel;
      slot = cfg_addr[7:4]; sel = cfg_addr[3:2];
      if (slot == 0 && sel == 0) m_filter = cfg_wdata;
      if (slot >= 1 && slot <= NC) begin
        if (sel == 0) m_ev[slot-1] = cfg_wdata[7:0];
        if (sel == 2) m_route[slot-1] = cfg_wdata[11:0];
      end
    end
  endtask

  task automatic cycle();
    predict();
    model_cfg();
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      int ab, ay;
      ab = burst_inc[c*BW +: BW];
      ay = byte_inc[c*YW +: YW];
      vectors++;
      if (ab != exp_b[c] || ay != exp_y[c]) begin
        miscompares++;
        $display("FAIL %s counter%0d: actual bursts=%0d bytes=%0d, expected bursts=%0d bytes=%0d",
                 cur_req, c + 1, ab, ay, exp_b[c], exp_y[c]);
      end
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cycle();
    cfg_we = 1'b0;
  endtask

  task automatic idle();
    ar_valid = '0; ar_ready = '0; aw_valid = '0; aw_ready = '0;
  endtask

  task automatic set_ar(input int p, input logic v, input logic r, input logic [15:0] id,
                        input logic [7:0] ln, input logic [2:0] sz);
    ar_valid[p] = v; ar_ready[p] = r; ar_id[p*16 +: 16] = id;
    ar_len[p*LW +: LW] = ln; ar_size[p*SW +: SW] = sz;
  endtask

  task automatic set_aw(input int p, input logic v, input logic r, input logic [15:0] id,
                        input logic [7:0] ln, input logic [2:0] sz);
    aw_valid[p] = v; aw_ready[p] = r; aw_id[p*16 +: 16] = id;
    aw_len[p*LW +: LW] = ln; aw_size[p*SW +: SW] = sz;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL R4 watchdog: actual run still going, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    rst = 1'b1;
    repeat (3) cycle();
    rst = 1'b0;
    cycle();
    cycle();

    // R9: programming, each write effective next cycle
    cur_req = "R9";
    wr(8'h10, 32'h41);
    wr(8'h20, 32'h42);
    wr(8'h30, 32'h05);
    wr(8'h00, 32'h0000_1234);
    wr(8'h18, 32'h0808);
    wr(8'h28, 32'h0808);
    wr(8'h38, 32'h0808);

    // R4: handshake rules and latency
    cur_req = "R4";
    set_ar(0, 1, 1, 16'h1234, 8'd3, 3'd2); cycle();
    idle(); cycle();
    set_ar(0, 1, 0, 16'h1234, 8'd3, 3'd2); cycle();
    set_ar(0, 0, 1, 16'h1234, 8'd3, 3'd2); cycle();
    idle();

    // R2: ID match with inverted mask half
    cur_req = "R2";
    set_ar(0, 1, 1, 16'h1235, 8'd0, 3'd0); cycle();
    idle();
    wr(8'h00, 32'h00FF_1200);
    set_ar(0, 1, 1, 16'h12AB, 8'd1, 3'd0); cycle();
    set_ar(0, 1, 1, 16'h13AB, 8'd1, 3'd0); cycle();
    idle(); cycle();

    // R5: byte arithmetic extremes
    cur_req = "R5";
    set_ar(1, 1, 1, 16'h1200, 8'd0, 3'd0); cycle();
    set_ar(1, 1, 1, 16'h1200, 8'd255, 3'd7); cycle();
    set_aw(0, 1, 1, 16'h12FF, 8'd15, 3'd4); cycle();
    idle(); cycle();

    // R7: all channels and ports at once
    cur_req = "R7";
    set_ar(0, 1, 1, 16'h1201, 8'd2, 3'd1);
    set_ar(1, 1, 1, 16'h1202, 8'd3, 3'd3);
    set_aw(0, 1, 1, 16'h1203, 8'd4, 3'd2);
    set_aw(1, 1, 1, 16'h1204, 8'd5, 3'd0);
    cycle();
    cycle();

    // R6: port routing with inverted select
    cur_req = "R6";
    wr(8'h18, 32'h0001);
    wr(8'h28, 32'h0100);
    cycle();
    wr(8'h28, 32'h0000);
    cycle();
    wr(8'h18, 32'h0002);
    cycle();
    wr(8'h18, 32'h0808);
    wr(8'h28, 32'h0808);

    // R3: event code selection
    cur_req = "R3";
    cycle();
    wr(8'h30, 32'h42);
    cycle();
    wr(8'h10, 32'h42);
    cycle();
    wr(8'h10, 32'h43);
    cycle();
    wr(8'h10, 32'h41);
    cycle();

    // R8: per-counter filter words ignored in shared build
    cur_req = "R8";
    wr(8'h14, 32'h0000_FFFF);
    wr(8'h24, 32'hFFFF_0000);
    cycle();
    idle();
    set_ar(0, 1, 1, 16'h1299, 8'd0, 3'd0); cycle();
    set_ar(0, 1, 1, 16'h5599, 8'd0, 3'd0); cycle();

    // R9: write in the same cycle as a handshake uses the old filter
    cur_req = "R9";
    idle();
    set_ar(0, 1, 1, 16'h9999, 8'd7, 3'd1);
    cfg_we = 1'b1; cfg_addr = 8'h00; cfg_wdata = 32'hFFFF_0000;
    cycle();
    cfg_we = 1'b0;
    cycle();
    wr(8'h02, 32'h0000_1234); // unaligned address: ignored
    cycle();
    idle(); cycle();

    // Random traffic and configuration churn
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      for (int p = 0; p < NP; p++) begin
        set_ar(p, 1'($urandom), 1'($urandom), 16'h1230 | 16'($urandom_range(0, 15)),
               8'($urandom), 3'($urandom));
        set_aw(p, 1'($urandom), 1'($urandom), 16'h1230 | 16'($urandom_range(0, 15)),
               8'($urandom), 3'($urandom));
      end
      if ($urandom_range(0, 19) == 0) begin
        int n, k;
        logic [31:0] d;
        n = $urandom_range(0, NC);
        k = $urandom_range(0, 2);
        case (k)
          0: d = (n == 0) ? {16'($urandom) & 16'h000F, 16'h1230 | 16'($urandom_range(0, 15))}
                          : 32'(($urandom_range(0, 2) == 0) ? 'h05 :
                                ($urandom_range(0, 1) ? 'h41 : 'h42));
          1: d = $urandom;
          default: d = $urandom & 32'h0F0F;
        endcase
        if (n == 0) k = 0;
        cfg_we = 1'b1; cfg_addr = 8'(n * 16 + k * 4); cfg_wdata = d;
      end
      cycle();
      cfg_we = 1'b0;
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule